// File: doc/BRIEF.md
# Hardware Trap Priority Controller

This block takes run-time exception strobes from the processor core and records each one in its own sticky flag bit. It then chooses which trap the core services next and tells the CPU sequencer about that choice with a one-cycle take strobe. Along with the strobe it gives the trap number, the full vector address and the priority rank of that trap. Hardware traps belong to three classes with fixed levels. Only a trap from a strictly higher level than the highest one already in service may nest on top of it. While any hardware trap is in service, a busy output tells the ordinary interrupt controller to hold off.

Several fault causes share one vector, and software tells them apart by reading the flag bits. Software clears those bits with a write-one-to-clear access. Software trap instructions come in as a request that carries a trap number. They run at the current CPU priority and never raise busy. The vector address is the segment value placed above the trap number shifted left by a programmable spacing.

Top module: `trap_ctrl`

## Requirements
- R1: During and right after reset, take_o, trap_num_o, vec_addr_o, act_rank_o, busy_o and flags_o are all zero.
- R2: A class A strobe a_req_i[i] sets flags_o[i], and a class B strobe b_req_i[j] sets flags_o[4+j], on the next clock edge. Flag bits stay set until they are cleared.
- R3: When flag_clr_we_i is high, each flag bit whose flag_clr_data_i bit is 1 is cleared. If a strobe sets the same bit in the same cycle, the bit ends up set.
- R4: A request that is latched at one edge is taken at the following edge. The order is: reset request (number 00h, level III) first, then class A in increasing number (a_req_i[i] maps to number 2*(i+1), so 02h, 04h, 06h, 08h, all at level II), then class B.
- R5: All class B causes use number 0Ah at level I. Class B causes that are pending together produce a single take.
- R6: A hardware trap is taken only when its level is strictly above the highest level in service. act_rank_o is 16, 17 or 18 for level I, II or III.
- R7: busy_o is high while any hardware level is in service. reti_i retires the highest level in service, and busy_o falls only after reti_i.
- R8: vec_addr_o is {vec_seg_i, trap number << (2 + vec_sc_i)}, using the inputs as they stand at the take edge. This gives 4, 8, 16 or 32 bytes per vector.
- R9: A software request latches its number (00h to 7Fh) into a single pending slot. It is taken only when no hardware trap can be taken, with act_rank_o equal to cpu_prio_i at the take edge, and it leaves busy_o unchanged. A new request is dropped while the slot stays occupied.
- R10: A software request with a number from 0Bh to 0Fh is dropped, and take_o never reports such a number.
- R11: take_o is high for exactly one cycle per taken trap. trap_num_o, vec_addr_o and act_rank_o hold their values until the next take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rst_req_i | input | 1 | Reset-function trap request strobe |
| a_req_i | input | 4 | Class A cause strobes, bit i gives number 2*(i+1) |
| b_req_i | input | 5 | Class B cause strobes |
| sw_req_i | input | 1 | Software trap request |
| sw_num_i | input | 7 | Software trap number |
| cpu_prio_i | input | 4 | Current CPU priority |
| reti_i | input | 1 | Return from trap |
| flag_clr_we_i | input | 1 | Flag clear write strobe |
| flag_clr_data_i | input | 9 | Write-one-to-clear mask |
| vec_seg_i | input | 8 | Vector segment |
| vec_sc_i | input | 2 | Vector spacing selector |
| take_o | output | 1 | Take-trap strobe |
| trap_num_o | output | 7 | Number of the trap taken |
| vec_addr_o | output | 24 | Vector address |
| act_rank_o | output | 5 | Priority rank of the trap taken |
| busy_o | output | 1 | Hardware trap in service |
| flags_o | output | 9 | Sticky trap flag bits |

## Verification
The bench first raises every hardware cause and a software request in one cycle, with returns spaced out. This separates strict class order, the single take for merged class B causes and the software request waiting behind hardware. Class B and then class A are raised while a lower class is in service, which checks that nesting follows level alone. A reserved software number and a sweep of all four spacing codes under a fixed segment check dropping and address shifting. A long random run mixes clears that collide with new strobes, returns given with nothing in service, and changing CPU priority, so that stickiness and clear-versus-set precedence are exercised.

// File: rtl/trap_pkg.sv
package trap_pkg;

    typedef enum logic [1:0] {
        LVL_NONE = 2'd0,
        LVL_I    = 2'd1,
        LVL_II   = 2'd2,
        LVL_III  = 2'd3
    } trap_lvl_e;

    localparam int unsigned TN_RESET  = 0;
    localparam int unsigned TN_RSV_LO = 11;
    localparam int unsigned TN_RSV_HI = 15;
    localparam int unsigned MIN_SHIFT = 2;

    // Number of class A cause idx (0-based)
    function automatic int unsigned class_a_num(input int unsigned idx);
        return 2 * (idx + 1);
    endfunction

    // Shared number of class B, placed after the last class A number
    function automatic int unsigned class_b_num(input int unsigned n_a);
        return 2 * (n_a + 1);
    endfunction

endpackage

// File: rtl/trap_flags.sv
module trap_flags #(
    parameter  int unsigned NUM_A  = 4,
    parameter  int unsigned NUM_B  = 5,
    localparam int unsigned FLAG_W = NUM_A + NUM_B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_req_i,
    input  logic [NUM_A-1:0]  a_req_i,
    input  logic [NUM_B-1:0]  b_req_i,
    input  logic              clr_we_i,
    input  logic [FLAG_W-1:0] clr_data_i,
    input  logic              grant_rst_i,
    input  logic [NUM_A-1:0]  grant_a_i,
    input  logic              grant_b_i,
    output logic [FLAG_W-1:0] flags_o,
    output logic              pend_rst_o,
    output logic [NUM_A-1:0]  pend_a_o,
    output logic              pend_b_o
);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic              p_rst;
        logic [NUM_A-1:0]  p_a;
        logic              p_b;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // clear first, new events win over the clear
        if (clr_we_i) begin
            st_d.flags = st_q.flags & ~clr_data_i;
        end
        st_d.flags = st_d.flags | {b_req_i, a_req_i};
        // pending bits: dropped when granted, re-armed by a new strobe
        st_d.p_rst = (st_q.p_rst & ~grant_rst_i) | rst_req_i;
        st_d.p_a   = (st_q.p_a & ~grant_a_i) | a_req_i;
        st_d.p_b   = (st_q.p_b & ~grant_b_i) | (|b_req_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o    = st_q.flags;
    assign pend_rst_o = st_q.p_rst;
    assign pend_a_o   = st_q.p_a;
    assign pend_b_o   = st_q.p_b;

endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
#(
    parameter int unsigned NUM_A = 4,
    parameter int unsigned NUM_W = 7
) (
    input  logic             pend_rst_i,
    input  logic [NUM_A-1:0] pend_a_i,
    input  logic             pend_b_i,
    input  logic             sw_pend_i,
    input  logic [NUM_W-1:0] sw_num_i,
    input  logic [2:0]       isv_i,
    output logic             win_o,
    output logic             win_sw_o,
    output trap_lvl_e        win_lvl_o,
    output logic [NUM_W-1:0] win_num_o,
    output logic             grant_rst_o,
    output logic [NUM_A-1:0] grant_a_o,
    output logic             grant_b_o
);

    trap_lvl_e        top_lvl;
    logic [NUM_A-1:0] a_first;
    logic             a_any;

    // highest level currently in service
    always_comb begin
        top_lvl = LVL_NONE;
        if (isv_i[2]) begin
            top_lvl = LVL_III;
        end else if (isv_i[1]) begin
            top_lvl = LVL_II;
        end else if (isv_i[0]) begin
            top_lvl = LVL_I;
        end
    end

    // lowest-numbered pending class A cause
    always_comb begin : pick_a
        logic seen;
        seen    = 1'b0;
        a_first = '0;
        for (int i = 0; i < NUM_A; i++) begin
            if (pend_a_i[i] && !seen) begin
                a_first[i] = 1'b1;
                seen       = 1'b1;
            end
        end
    end

    assign a_any = |pend_a_i;

    always_comb begin
        win_o       = 1'b0;
        win_sw_o    = 1'b0;
        win_lvl_o   = LVL_NONE;
        win_num_o   = '0;
        grant_rst_o = 1'b0;
        grant_a_o   = '0;
        grant_b_o   = 1'b0;
        if (pend_rst_i && (top_lvl < LVL_III)) begin
            win_o       = 1'b1;
            win_lvl_o   = LVL_III;
            win_num_o   = NUM_W'(TN_RESET);
            grant_rst_o = 1'b1;
        end else if (a_any && (top_lvl < LVL_II)) begin
            win_o     = 1'b1;
            win_lvl_o = LVL_II;
            grant_a_o = a_first;
            for (int i = 0; i < NUM_A; i++) begin
                if (a_first[i]) begin
                    win_num_o = NUM_W'(class_a_num(i));
                end
            end
        end else if (pend_b_i && (top_lvl < LVL_I)) begin
            win_o     = 1'b1;
            win_lvl_o = LVL_I;
            win_num_o = NUM_W'(class_b_num(NUM_A));
            grant_b_o = 1'b1;
        end else if (sw_pend_i) begin
            win_o     = 1'b1;
            win_sw_o  = 1'b1;
            win_num_o = sw_num_i;
        end
    end

endmodule

// File: rtl/trap_vector.sv
module trap_vector
    import trap_pkg::*;
#(
    parameter  int unsigned SEG_W  = 8,
    parameter  int unsigned OFS_W  = 16,
    parameter  int unsigned NUM_W  = 7,
    localparam int unsigned ADDR_W = SEG_W + OFS_W,
    localparam int unsigned N_SC   = 4
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [1:0]        sc_i,
    input  logic [NUM_W-1:0]  num_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [OFS_W-1:0] ofs_opt [N_SC];

    for (genvar g = 0; g < N_SC; g++) begin : g_space
        assign ofs_opt[g] = OFS_W'(num_i) << (MIN_SHIFT + g);
    end

    assign addr_o = {seg_i, ofs_opt[sc_i]};

endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter  int unsigned CPU_PRIO_W = 4,
    parameter  int unsigned SEG_W      = 8,
    parameter  int unsigned OFS_W      = 16,
    parameter  int unsigned NUM_W      = 7,
    parameter  int unsigned NUM_A      = 4,
    parameter  int unsigned NUM_B      = 5,
    localparam int unsigned FLAG_W     = NUM_A + NUM_B,
    localparam int unsigned ADDR_W     = SEG_W + OFS_W,
    localparam int unsigned RANK_W     = CPU_PRIO_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rst_req_i,
    input  logic [NUM_A-1:0]      a_req_i,
    input  logic [NUM_B-1:0]      b_req_i,
    input  logic                  sw_req_i,
    input  logic [NUM_W-1:0]      sw_num_i,
    input  logic [CPU_PRIO_W-1:0] cpu_prio_i,
    input  logic                  reti_i,
    input  logic                  flag_clr_we_i,
    input  logic [FLAG_W-1:0]     flag_clr_data_i,
    input  logic [SEG_W-1:0]      vec_seg_i,
    input  logic [1:0]            vec_sc_i,
    output logic                  take_o,
    output logic [NUM_W-1:0]      trap_num_o,
    output logic [ADDR_W-1:0]     vec_addr_o,
    output logic [RANK_W-1:0]     act_rank_o,
    output logic                  busy_o,
    output logic [FLAG_W-1:0]     flags_o
);

    localparam logic [RANK_W-1:0] HW_RANK0 = RANK_W'(1 << CPU_PRIO_W);

    typedef struct packed {
        logic [2:0]        isv;
        logic              sw_pend;
        logic [NUM_W-1:0]  sw_num;
        logic              take;
        logic [NUM_W-1:0]  num;
        logic [ADDR_W-1:0] addr;
        logic [RANK_W-1:0] rank;
    } ctl_st_t;

    ctl_st_t st_d, st_q;

    logic              pend_rst;
    logic [NUM_A-1:0]  pend_a;
    logic              pend_b;
    logic              win;
    logic              win_sw;
    trap_lvl_e         win_lvl;
    logic [NUM_W-1:0]  win_num;
    logic              grant_rst;
    logic [NUM_A-1:0]  grant_a;
    logic              grant_b;
    logic [ADDR_W-1:0] win_addr;
    logic [2:0]        isv_n;
    logic              sw_keep;
    logic              sw_rsv;

    trap_flags #(
        .NUM_A (NUM_A),
        .NUM_B (NUM_B)
    ) u_flags (
        .clk         (clk),
        .rst_n       (rst_n),
        .rst_req_i   (rst_req_i),
        .a_req_i     (a_req_i),
        .b_req_i     (b_req_i),
        .clr_we_i    (flag_clr_we_i),
        .clr_data_i  (flag_clr_data_i),
        .grant_rst_i (grant_rst),
        .grant_a_i   (grant_a),
        .grant_b_i   (grant_b),
        .flags_o     (flags_o),
        .pend_rst_o  (pend_rst),
        .pend_a_o    (pend_a),
        .pend_b_o    (pend_b)
    );

    trap_arbiter #(
        .NUM_A (NUM_A),
        .NUM_W (NUM_W)
    ) u_arb (
        .pend_rst_i  (pend_rst),
        .pend_a_i    (pend_a),
        .pend_b_i    (pend_b),
        .sw_pend_i   (st_q.sw_pend),
        .sw_num_i    (st_q.sw_num),
        .isv_i       (st_q.isv),
        .win_o       (win),
        .win_sw_o    (win_sw),
        .win_lvl_o   (win_lvl),
        .win_num_o   (win_num),
        .grant_rst_o (grant_rst),
        .grant_a_o   (grant_a),
        .grant_b_o   (grant_b)
    );

    trap_vector #(
        .SEG_W (SEG_W),
        .OFS_W (OFS_W),
        .NUM_W (NUM_W)
    ) u_vec (
        .seg_i  (vec_seg_i),
        .sc_i   (vec_sc_i),
        .num_i  (win_num),
        .addr_o (win_addr)
    );

    assign sw_rsv = (32'(sw_num_i) >= TN_RSV_LO) && (32'(sw_num_i) <= TN_RSV_HI);

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;

        // nesting mask: retire the top level, then mark a new hardware level
        isv_n = st_q.isv;
        if (reti_i) begin
            if (isv_n[2]) begin
                isv_n[2] = 1'b0;
            end else if (isv_n[1]) begin
                isv_n[1] = 1'b0;
            end else begin
                isv_n[0] = 1'b0;
            end
        end
        if (win && !win_sw) begin
            case (win_lvl)
                LVL_I:   isv_n[0] = 1'b1;
                LVL_II:  isv_n[1] = 1'b1;
                LVL_III: isv_n[2] = 1'b1;
                default: ;
            endcase
        end
        st_d.isv = isv_n;

        // single software slot
        sw_keep = st_q.sw_pend && !(win && win_sw);
        if (!sw_keep && sw_req_i && !sw_rsv) begin
            st_d.sw_pend = 1'b1;
            st_d.sw_num  = sw_num_i;
        end else begin
            st_d.sw_pend = sw_keep;
        end

        if (win) begin
            st_d.take = 1'b1;
            st_d.num  = win_num;
            st_d.addr = win_addr;
            if (win_sw) begin
                st_d.rank = RANK_W'(cpu_prio_i);
            end else begin
                st_d.rank = HW_RANK0 + RANK_W'(win_lvl) - RANK_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign take_o     = st_q.take;
    assign trap_num_o = st_q.num;
    assign vec_addr_o = st_q.addr;
    assign act_rank_o = st_q.rank;
    assign busy_o     = |st_q.isv;

endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk
    import trap_pkg::*;
#(
    parameter  int unsigned CPU_PRIO_W = 4,
    parameter  int unsigned SEG_W      = 8,
    parameter  int unsigned OFS_W      = 16,
    parameter  int unsigned NUM_W      = 7,
    parameter  int unsigned NUM_A      = 4,
    parameter  int unsigned NUM_B      = 5,
    localparam int unsigned FLAG_W     = NUM_A + NUM_B,
    localparam int unsigned ADDR_W     = SEG_W + OFS_W,
    localparam int unsigned RANK_W     = CPU_PRIO_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reti_i,
    input logic              flag_clr_we_i,
    input logic [SEG_W-1:0]  vec_seg_i,
    input logic [1:0]        vec_sc_i,
    input logic              take_o,
    input logic [NUM_W-1:0]  trap_num_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic [RANK_W-1:0] act_rank_o,
    input logic              busy_o,
    input logic [FLAG_W-1:0] flags_o
);

    localparam logic [RANK_W-1:0] RK_I   = RANK_W'(1 << CPU_PRIO_W);
    localparam logic [RANK_W-1:0] RK_III = RANK_W'((1 << CPU_PRIO_W) + 2);

    AST_RSV_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> !((32'(trap_num_o) >= TN_RSV_LO) && (32'(trap_num_o) <= TN_RSV_HI)))
        else $error("reserved trap number taken"); // R10

    AST_VEC_SEGMENT: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_addr_o[ADDR_W-1:OFS_W] == $past(vec_seg_i)))
        else $error("vector segment mismatch"); // R8

    AST_VEC_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (vec_addr_o[OFS_W-1:0] ==
                    (OFS_W'(trap_num_o) << (MIN_SHIFT + 32'($past(vec_sc_i))))))
        else $error("vector offset mismatch"); // R8

    AST_SHARED_B_NUM: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (act_rank_o == RK_I)) |-> (32'(trap_num_o) == class_b_num(NUM_A)))
        else $error("class B number mismatch"); // R5

    AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (act_rank_o == RK_III)) |-> (32'(trap_num_o) == TN_RESET))
        else $error("reset trap number mismatch"); // R4

    AST_HW_TAKE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (act_rank_o >= RK_I)) |-> busy_o)
        else $error("hardware take without busy"); // R7

    AST_BUSY_FALL_RETI: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(reti_i))
        else $error("busy dropped without return"); // R7

    AST_FLAG_ONLY_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(flags_o) & ~flags_o)) |-> $past(flag_clr_we_i))
        else $error("flag fell without clear write"); // R3

endmodule

bind trap_ctrl trap_ctrl_chk #(
    .CPU_PRIO_W (CPU_PRIO_W),
    .SEG_W      (SEG_W),
    .OFS_W      (OFS_W),
    .NUM_W      (NUM_W),
    .NUM_A      (NUM_A),
    .NUM_B      (NUM_B)
) i_chk (.*);

// File: tb/test_trap_ctrl.sv
module test_trap_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req_i = 1'b0;
    logic [3:0]  a_req_i = '0;
    logic [4:0]  b_req_i = '0;
    logic        sw_req_i = 1'b0;
    logic [6:0]  sw_num_i = '0;
    logic [3:0]  cpu_prio_i = '0;
    logic        reti_i = 1'b0;
    logic        flag_clr_we_i = 1'b0;
    logic [8:0]  flag_clr_data_i = '0;
    logic [7:0]  vec_seg_i = '0;
    logic [1:0]  vec_sc_i = '0;
    logic        take_o;
    logic [6:0]  trap_num_o;
    logic [23:0] vec_addr_o;
    logic [4:0]  act_rank_o;
    logic        busy_o;
    logic [8:0]  flags_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    trap_ctrl i_trap_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .rst_req_i       (rst_req_i),
        .a_req_i         (a_req_i),
        .b_req_i         (b_req_i),
        .sw_req_i        (sw_req_i),
        .sw_num_i        (sw_num_i),
        .cpu_prio_i      (cpu_prio_i),
        .reti_i          (reti_i),
        .flag_clr_we_i   (flag_clr_we_i),
        .flag_clr_data_i (flag_clr_data_i),
        .vec_seg_i       (vec_seg_i),
        .vec_sc_i        (vec_sc_i),
        .take_o          (take_o),
        .trap_num_o      (trap_num_o),
        .vec_addr_o      (vec_addr_o),
        .act_rank_o      (act_rank_o),
        .busy_o          (busy_o),
        .flags_o         (flags_o)
    );

    int n_chk = 0;
    int n_bad = 0;

    // behavioural reference state
    bit          m_prst;
    bit          m_pa [4];
    bit          m_pb;
    bit          m_swp;
    int          m_swn;
    bit          m_isv [1:3];
    bit [8:0]    m_flags;
    bit          m_take;
    int          m_num;
    logic [23:0] m_addr;
    int          m_rank;

    function automatic bit m_busy();
        return m_isv[1] || m_isv[2] || m_isv[3];
    endfunction

    task automatic model_reset();
        m_prst = 0; m_pb = 0; m_swp = 0; m_swn = 0; m_flags = '0;
        m_take = 0; m_num = 0; m_addr = '0; m_rank = 0;
        for (int i = 0; i < 4; i++) m_pa[i] = 0;
        for (int l = 1; l <= 3; l++) m_isv[l] = 0;
    endtask

    task automatic model_step();
        int top = 0;
        bit got = 0;
        bit csw = 0;
        int clvl = 0;
        int cnum = 0;
        int ca = -1;
        for (int l = 1; l <= 3; l++) if (m_isv[l]) top = l;
        if (m_prst && top < 3) begin
            got = 1; clvl = 3; cnum = 0;
        end else begin
            for (int i = 0; i < 4; i++) begin
                if (!got && m_pa[i] && top < 2) begin
                    got = 1; clvl = 2; cnum = 2 * (i + 1); ca = i;
                end
            end
            if (!got && m_pb && top < 1) begin
                got = 1; clvl = 1; cnum = 10;
            end
            if (!got && m_swp) begin
                got = 1; csw = 1; cnum = m_swn;
            end
        end
        if (reti_i && top > 0) m_isv[top] = 0;
        m_take = got;
        if (got) begin
            m_num  = cnum;
            m_addr = {vec_seg_i, 16'(cnum << (2 + int'(vec_sc_i)))};
            m_rank = csw ? int'(cpu_prio_i) : 15 + clvl;
            if (csw) begin
                m_swp = 0;
            end else begin
                m_isv[clvl] = 1;
                if (clvl == 3) m_prst = 0;
                else if (clvl == 2) m_pa[ca] = 0;
                else m_pb = 0;
            end
        end
        if (flag_clr_we_i) m_flags = m_flags & ~flag_clr_data_i;
        m_flags = m_flags | {b_req_i, a_req_i};
        if (rst_req_i) m_prst = 1;
        for (int i = 0; i < 4; i++) if (a_req_i[i]) m_pa[i] = 1;
        if (|b_req_i) m_pb = 1;
        if (!m_swp && sw_req_i && !(sw_num_i >= 7'd11 && sw_num_i <= 7'd15)) begin
            m_swp = 1; m_swn = int'(sw_num_i);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R11 take strobe", 32'(take_o), 32'(m_take));
        chk("R4/R5/R9/R10 trap number", 32'(trap_num_o), 32'(m_num));
        chk("R8 vector address", 32'(vec_addr_o), 32'(m_addr));
        chk("R6/R9 rank", 32'(act_rank_o), 32'(m_rank));
        chk("R7 busy", 32'(busy_o), 32'(m_busy()));
        chk("R2/R3 flags", 32'(flags_o), 32'(m_flags));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        compare();
        rst_req_i = 0; a_req_i = '0; b_req_i = '0; sw_req_i = 0;
        reti_i = 0; flag_clr_we_i = 0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired R11 actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin : main
        vec_seg_i = 8'h12;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 take", 32'(take_o), 0);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 flags", 32'(flags_o), 0);
        chk("R1 num", 32'(trap_num_o), 0);
        chk("R1 addr", 32'(vec_addr_o), 0);
        chk("R1 rank", 32'(act_rank_o), 0);
        rst_n = 1;
        tick();

        // everything at once: R4 ordering, R5 merge, R9 software waits
        rst_req_i = 1; a_req_i = 4'hF; b_req_i = 5'b10101;
        sw_req_i = 1; sw_num_i = 7'h30; cpu_prio_i = 4'd7;
        tick();
        for (int k = 0; k < 16; k++) begin
            reti_i = (k % 3 == 2);
            tick();
        end
        repeat (3) begin reti_i = 1; tick(); end

        // R10: reserved software number dropped
        sw_req_i = 1; sw_num_i = 7'h0C;
        tick(); tick(); tick();

        // R8: spacing sweep with a fixed segment
        vec_seg_i = 8'h5A;
        for (int s = 0; s < 4; s++) begin
            vec_sc_i = 2'(s);
            sw_req_i = 1; sw_num_i = 7'h7F;
            tick(); tick(); tick();
        end

        // R6: nesting, B first, then A, then reset
        b_req_i = 5'b00010; tick(); tick();
        a_req_i = 4'b0100; tick(); tick();
        rst_req_i = 1; tick(); tick();
        a_req_i = 4'b0001; tick(); tick();
        repeat (4) begin reti_i = 1; tick(); tick(); end

        // R3: clear colliding with a new strobe
        flag_clr_we_i = 1; flag_clr_data_i = 9'h1FF; a_req_i = 4'b0010;
        tick(); tick();
        reti_i = 1; tick();

        // random mix
        for (int c = 0; c < 6000; c++) begin
            rst_req_i       = ($urandom_range(0, 99) < 2);
            a_req_i         = 4'($urandom) & 4'($urandom) & 4'($urandom);
            b_req_i         = 5'($urandom) & 5'($urandom) & 5'($urandom) & 5'($urandom);
            sw_req_i        = ($urandom_range(0, 5) == 0);
            sw_num_i        = 7'($urandom);
            cpu_prio_i      = 4'($urandom);
            reti_i          = ($urandom_range(0, 3) == 0);
            flag_clr_we_i   = ($urandom_range(0, 7) == 0);
            flag_clr_data_i = 9'($urandom);
            vec_seg_i       = 8'($urandom);
            vec_sc_i        = 2'($urandom);
            tick();
        end

        summary();
        $finish;
    end

endmodule